// File: doc/BRIEF.md
# Periodic Trigger Pulse Sequencer

This block paces a position-capture campaign. Once started, it emits a fixed number of trigger pulses on an output pin, with a programmed spacing and pulse width. Each trigger also asks an external encoder master for one position read. It tracks how many reads came back good and how many came back bad. It also counts how many triggers were lost because the previous read had not finished, which is an overrun. Software can also ask for one read with no pulse, or fire one trigger outside a campaign.

The block also manages a byte of spare general-purpose I/O tied to the trigger. The input byte is sampled at each trigger. Output values and directions written beforehand stay pending, and reach the pins only at the next trigger. This lets external equipment change state in step with the acquisition.

Top module: `trig_seq`

## Requirements
- R1: After reset, `trig_pulse`, `running`, `acq_start` and `pos_ready` are 0. All three counters are 0, and `gpio_out`, `gpio_oe` and `gpio_in_lat` are 0.
- R2: The start strobe `act_start` is sampled at a clock edge. `running` is high from the next cycle onward. The first trigger is taken at the following edge. Later triggers are taken every `period_m1`+1 cycles.
- R3: A campaign fires exactly `count_m1`+1 triggers. `running` goes low in the same cycle that the last pulse goes high.
- R4: Each pulse on `trig_pulse` is high for exactly `width_m2`+2 consecutive cycles.
- R5: A trigger or a single-position request raises `acq_start` for one cycle, in the cycle the pulse rises, when no read is outstanding. A read is outstanding from that strobe until `enc_done` is sampled.
- R6: A trigger or a single-position request that arrives while a read is outstanding adds one to `cnt_ovr` and raises no `acq_start`.
- R7: `enc_done` with `enc_err` = 0 adds one to `cnt_acq` and raises `pos_ready` for one cycle. `enc_done` with `enc_err` = 1 adds one to `cnt_err` and raises no `pos_ready`.
- R8: The counters saturate at their all-ones value instead of wrapping. `cnt_acq` is 16 bits wide, and `cnt_err` and `cnt_ovr` are 8 bits each.
- R9: `act_start` sets all three counters to 0 in the cycle after it is sampled.
- R10: `act_single_trig` produces one pulse and one read request, and leaves `running` low. `act_single_pos` requests one read and produces no pulse.
- R11: `gpio_in` is captured into `gpio_in_lat` at each trigger and held between triggers. Values given with `gpio_wr` (`gpio_wr_val`, `gpio_wr_dir`, where 1 means drive) stay pending. They appear on `gpio_out`/`gpio_oe` only in the cycle the next pulse rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_m1 | input | 32 | Trigger spacing in cycles, minus one |
| count_m1 | input | 16 | Triggers per campaign, minus one |
| width_m2 | input | 16 | Pulse width in cycles, minus two |
| act_single_pos | input | 1 | Strobe: request one read without a pulse |
| act_start | input | 1 | Strobe: clear counters and start a campaign |
| act_single_trig | input | 1 | Strobe: fire one trigger |
| enc_done | input | 1 | Encoder read finished (one cycle) |
| enc_err | input | 1 | Qualifies `enc_done`: the read failed |
| gpio_in | input | 8 | Spare I/O input levels |
| gpio_wr | input | 1 | Strobe: load pending output value and direction |
| gpio_wr_val | input | 8 | Pending output value |
| gpio_wr_dir | input | 8 | Pending direction, 1 = drive |
| trig_pulse | output | 1 | Trigger pulse pin |
| running | output | 1 | Campaign in progress |
| acq_start | output | 1 | Read request strobe to the encoder master |
| pos_ready | output | 1 | New good position available |
| cnt_acq | output | 16 | Good reads, saturating |
| cnt_err | output | 8 | Failed reads, saturating |
| cnt_ovr | output | 8 | Overruns, saturating |
| gpio_in_lat | output | 8 | Input byte captured at the last trigger |
| gpio_out | output | 8 | Applied output value |
| gpio_oe | output | 8 | Applied output enables |

## Verification
The train is run with three configurations. A short spacing with a narrow pulse separates spacing errors from width errors. A single-trigger campaign with a wide pulse exposes off-by-one mistakes in the count and the width. A read latency longer than the spacing shows that the middle trigger is dropped while the first and last still start reads. Burst tests drive the error and overrun counters far past 255 to tell saturation from wrapping. Stand-alone strobes and the I/O test separate pulse-only, read-only and trigger-aligned behaviour from campaign behaviour.

// File: rtl/pts_pkg.sv
package pts_pkg;
    // Read-path control flags registered in the top.
    typedef struct packed {
        logic busy;       // a read is outstanding
        logic acq_start;  // read request strobe
        logic pos_ready;  // good position strobe
    } rd_ctl_t;
endpackage

// File: rtl/pts_sat_ctr.sv
module pts_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr)
            q_d = '0;
        else if (inc && q_q != MAXV)
            q_d = q_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/pts_period_timer.sv
module pts_period_timer #(
    parameter int PER_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PER_W-1:0] period_m1,
    input  logic [CNT_W-1:0] count_m1,
    output logic             running,
    output logic             fire
);
    typedef struct packed {
        logic             run;
        logic [PER_W-1:0] tick;
        logic [CNT_W-1:0] remain;
    } tmr_t;

    tmr_t st_d, st_q;

    assign fire    = st_q.run && (st_q.tick == '0);
    assign running = st_q.run;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.run    = 1'b1;
            st_d.tick   = '0;
            st_d.remain = count_m1;
        end else if (st_q.run) begin
            if (fire && st_q.remain == '0) begin
                st_d.run = 1'b0;
            end else begin
                st_d.tick = (st_q.tick == period_m1) ? '0 : st_q.tick + PER_W'(1);
                if (fire)
                    st_d.remain = st_q.remain - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pts_pulse_gen.sv
module pts_pulse_gen #(
    parameter int WID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [WID_W-1:0] width_m2,
    output logic             pulse
);
    localparam int CW = WID_W + 1;

    typedef struct packed {
        logic          on;
        logic [CW-1:0] cnt;
    } pg_t;

    pg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.on  = 1'b1;
            st_d.cnt = CW'({1'b0, width_m2}) + CW'(1);
        end else if (st_q.on) begin
            if (st_q.cnt == '0) st_d.on  = 1'b0;
            else                st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.on;
endmodule

// File: rtl/trig_seq.sv
module trig_seq #(
    parameter int PER_W = 32,
    parameter int CNT_W = 16,
    parameter int WID_W = 16,
    parameter int ACQ_W = 16,
    parameter int ERR_W = 8,
    parameter int OVR_W = 8,
    parameter int IO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_m1,
    input  logic [CNT_W-1:0] count_m1,
    input  logic [WID_W-1:0] width_m2,
    input  logic             act_single_pos,
    input  logic             act_start,
    input  logic             act_single_trig,
    input  logic             enc_done,
    input  logic             enc_err,
    input  logic [IO_W-1:0]  gpio_in,
    input  logic             gpio_wr,
    input  logic [IO_W-1:0]  gpio_wr_val,
    input  logic [IO_W-1:0]  gpio_wr_dir,
    output logic             trig_pulse,
    output logic             running,
    output logic             acq_start,
    output logic             pos_ready,
    output logic [ACQ_W-1:0] cnt_acq,
    output logic [ERR_W-1:0] cnt_err,
    output logic [OVR_W-1:0] cnt_ovr,
    output logic [IO_W-1:0]  gpio_in_lat,
    output logic [IO_W-1:0]  gpio_out,
    output logic [IO_W-1:0]  gpio_oe
);
    import pts_pkg::*;

    typedef struct packed {
        rd_ctl_t          rd;
        logic [IO_W-1:0]  gin;
        logic [IO_W-1:0]  pval;
        logic [IO_W-1:0]  pdir;
        logic [IO_W-1:0]  gout;
        logic [IO_W-1:0]  goe;
    } seq_t;

    seq_t st_d, st_q;

    logic fire_run, fire, req, issue, ovr_inc, acq_inc, err_inc;

    pts_period_timer #(.PER_W(PER_W), .CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (act_start),
        .period_m1(period_m1),
        .count_m1 (count_m1),
        .running  (running),
        .fire     (fire_run)
    );

    pts_pulse_gen #(.WID_W(WID_W)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .width_m2(width_m2),
        .pulse   (trig_pulse)
    );

    pts_sat_ctr #(.W(ACQ_W)) u_cnt_acq (
        .clk(clk), .rst_n(rst_n), .clr(act_start), .inc(acq_inc), .q(cnt_acq)
    );
    pts_sat_ctr #(.W(ERR_W)) u_cnt_err (
        .clk(clk), .rst_n(rst_n), .clr(act_start), .inc(err_inc), .q(cnt_err)
    );
    pts_sat_ctr #(.W(OVR_W)) u_cnt_ovr (
        .clk(clk), .rst_n(rst_n), .clr(act_start), .inc(ovr_inc), .q(cnt_ovr)
    );

    always_comb begin
        fire    = fire_run | act_single_trig;
        req     = fire | act_single_pos;
        issue   = req & ~st_q.rd.busy;
        ovr_inc = req &  st_q.rd.busy;
        acq_inc = enc_done & ~enc_err;
        err_inc = enc_done &  enc_err;

        st_d = st_q;
        st_d.rd.acq_start = issue;
        st_d.rd.pos_ready = acq_inc;
        if (issue)         st_d.rd.busy = 1'b1;
        else if (enc_done) st_d.rd.busy = 1'b0;

        if (gpio_wr) begin
            st_d.pval = gpio_wr_val;
            st_d.pdir = gpio_wr_dir;
        end
        if (fire) begin
            st_d.gin  = gpio_in;
            st_d.gout = st_q.pval;
            st_d.goe  = st_q.pdir;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acq_start   = st_q.rd.acq_start;
    assign pos_ready   = st_q.rd.pos_ready;
    assign gpio_in_lat = st_q.gin;
    assign gpio_out    = st_q.gout;
    assign gpio_oe     = st_q.goe;
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
    parameter int ACQ_W = 16,
    parameter int ERR_W = 8,
    parameter int OVR_W = 8,
    parameter int IO_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             act_start,
    input logic             enc_done,
    input logic             enc_err,
    input logic             trig_pulse,
    input logic             running,
    input logic             acq_start,
    input logic             pos_ready,
    input logic [ACQ_W-1:0] cnt_acq,
    input logic [ERR_W-1:0] cnt_err,
    input logic [OVR_W-1:0] cnt_ovr,
    input logic [IO_W-1:0]  gpio_out,
    input logic [IO_W-1:0]  gpio_oe
);
    p_req_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> !acq_start);

    p_ready_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pos_ready |-> $past(enc_done && !enc_err));

    p_ovr_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ovr == '1 && !act_start) |=> cnt_ovr == '1);

    p_acq_monotonic_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !act_start |=> cnt_acq >= $past(cnt_acq));

    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act_start |=> (cnt_acq == '0 && cnt_err == '0 && cnt_ovr == '0));

    p_run_ends_on_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> trig_pulse);

    p_gpio_on_trigger_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({gpio_out, gpio_oe}) |-> trig_pulse);
endmodule

bind trig_seq trig_seq_chk #(
    .ACQ_W(ACQ_W), .ERR_W(ERR_W), .OVR_W(OVR_W), .IO_W(IO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_start (act_start),
    .enc_done  (enc_done),
    .enc_err   (enc_err),
    .trig_pulse(trig_pulse),
    .running   (running),
    .acq_start (acq_start),
    .pos_ready (pos_ready),
    .cnt_acq   (cnt_acq),
    .cnt_err   (cnt_err),
    .cnt_ovr   (cnt_ovr),
    .gpio_out  (gpio_out),
    .gpio_oe   (gpio_oe)
);

// File: tb/trig_seq_tb.sv
`timescale 1ns/1ps
module trig_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] period_m1 = '0;
    logic [15:0] count_m1 = '0;
    logic [15:0] width_m2 = '0;
    logic        act_single_pos = 1'b0, act_start = 1'b0, act_single_trig = 1'b0;
    logic        enc_done = 1'b0, enc_err = 1'b0;
    logic [7:0]  gpio_in = '0, gpio_wr_val = '0, gpio_wr_dir = '0;
    logic        gpio_wr = 1'b0;
    logic        trig_pulse, running, acq_start, pos_ready;
    logic [15:0] cnt_acq;
    logic [7:0]  cnt_err, cnt_ovr, gpio_in_lat, gpio_out, gpio_oe;

    int nchk = 0;
    int nfail = 0;
    int enc_lat = 3;
    logic err_mode = 1'b0;

    always #2 clk = ~clk;

    trig_seq u_dut (
        .clk(clk), .rst_n(rst_n), .period_m1(period_m1), .count_m1(count_m1),
        .width_m2(width_m2), .act_single_pos(act_single_pos), .act_start(act_start),
        .act_single_trig(act_single_trig), .enc_done(enc_done), .enc_err(enc_err),
        .gpio_in(gpio_in), .gpio_wr(gpio_wr), .gpio_wr_val(gpio_wr_val),
        .gpio_wr_dir(gpio_wr_dir), .trig_pulse(trig_pulse), .running(running),
        .acq_start(acq_start), .pos_ready(pos_ready), .cnt_acq(cnt_acq),
        .cnt_err(cnt_err), .cnt_ovr(cnt_ovr), .gpio_in_lat(gpio_in_lat),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe)
    );

    // Encoder model: answers each read request after enc_lat cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (acq_start) begin
                repeat (enc_lat) @(negedge clk);
                enc_done = 1'b1;
                enc_err  = err_mode;
                @(negedge clk);
                enc_done = 1'b0;
                enc_err  = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        act_single_pos = 0; act_start = 0; act_single_trig = 0; gpio_wr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1 trig_pulse", trig_pulse, 0);
        chk("R1 running", running, 0);
        chk("R1 acq_start/pos_ready", {acq_start, pos_ready}, 0);
        chk("R1 counters", {cnt_acq, cnt_err, cnt_ovr}, 0);
        chk("R1 gpio", {gpio_out, gpio_oe, gpio_in_lat}, 0);
    endtask

    task automatic run_train(input int p, input int n, input int w, input int lat,
                             input int exp_acq, input int exp_ovr);
        int first = -1, last = -1, rises = 0, high = 0, fall = -1;
        int bad_gap = 0, nacq = 0, nrdy = 0, len;
        logic prev = 0;
        do_reset();
        enc_lat = lat; err_mode = 0;
        period_m1 = p; count_m1 = 16'(n - 1); width_m2 = 16'(w);
        act_start = 1'b1;
        @(negedge clk);
        act_start = 1'b0;
        chk("R2 running after start", running, 1);
        chk("R2 no pulse yet", trig_pulse, 0);
        len = 1 + (n - 1) * (p + 1) + w + lat + 40;
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            if (trig_pulse && !prev) begin
                rises++;
                if (first < 0) first = i;
                else if (i - last != p + 1) bad_gap++;
                last = i;
            end
            if (trig_pulse) high++;
            if (acq_start) nacq++;
            if (pos_ready) nrdy++;
            if (!running && fall < 0) fall = i;
            prev = trig_pulse;
        end
        chk("R2 first trigger cycle", first, 1);
        chk("R2 trigger spacing errors", bad_gap, 0);
        chk("R3 trigger count", rises, n);
        chk("R3 running fall cycle", fall, 1 + (n - 1) * (p + 1));
        chk("R4 total pulse-high cycles", high, n * (w + 2));
        chk("R5 read requests", nacq, exp_acq);
        chk("R6 overrun count", cnt_ovr, exp_ovr);
        chk("R7 good count", cnt_acq, exp_acq);
        chk("R7 pos_ready strobes", nrdy, exp_acq);
    endtask

    task automatic test_single();
        int high = 0, nacq = 0, run_seen = 0;
        do_reset();
        enc_lat = 3; err_mode = 0; width_m2 = 16'd2;
        act_single_trig = 1'b1;
        @(negedge clk);
        act_single_trig = 1'b0;
        chk("R10 single trig pulse starts", trig_pulse, 1);
        chk("R5 single trig read strobe", acq_start, 1);
        for (int i = 0; i < 20; i++) begin
            if (trig_pulse) high++;
            if (running) run_seen++;
            @(negedge clk);
        end
        chk("R10 single trig width", high, 4);
        chk("R10 running stays low", run_seen, 0);
        chk("R7 single trig good read", cnt_acq, 1);
        act_single_pos = 1'b1;
        @(negedge clk);
        act_single_pos = 1'b0;
        high = 0;
        for (int i = 0; i < 20; i++) begin
            if (trig_pulse) high++;
            if (acq_start) nacq++;
            @(negedge clk);
        end
        chk("R10 single pos gives no pulse", high, 0);
        chk("R10 single pos read strobe", nacq, 1);
        chk("R7 single pos good read", cnt_acq, 2);
        // counters are non-zero here; a start must clear them
        period_m1 = 32'd50; count_m1 = 16'd0;
        act_start = 1'b1;
        @(negedge clk);
        act_start = 1'b0;
        chk("R9 start clears counters", {cnt_acq, cnt_err, cnt_ovr}, 0);
        repeat (80) @(negedge clk);
    endtask

    task automatic test_saturation();
        int nrdy = 0;
        do_reset();
        enc_lat = 1; err_mode = 1;
        for (int k = 0; k < 260; k++) begin
            act_single_pos = 1'b1;
            @(negedge clk);
            act_single_pos = 1'b0;
            for (int j = 0; j < 5; j++) begin
                @(negedge clk);
                if (pos_ready) nrdy++;
            end
        end
        chk("R8 error count saturates", cnt_err, 8'hFF);
        chk("R7 errors leave good count", cnt_acq, 0);
        chk("R7 errors raise no pos_ready", nrdy, 0);
        err_mode = 0; enc_lat = 2000; width_m2 = 16'd0;
        for (int k = 0; k < 300; k++) begin
            act_single_trig = 1'b1;
            @(negedge clk);
            act_single_trig = 1'b0;
            @(negedge clk);
        end
        chk("R8 overrun count saturates", cnt_ovr, 8'hFF);
        chk("R6 only first read issued", cnt_acq, 0);
        repeat (2100) @(negedge clk);
        chk("R7 delayed read completes", cnt_acq, 1);
        enc_lat = 3;
    endtask

    task automatic test_gpio();
        do_reset();
        enc_lat = 3; err_mode = 0; width_m2 = 16'd0;
        gpio_wr_val = 8'hA5; gpio_wr_dir = 8'h0F; gpio_wr = 1'b1;
        @(negedge clk);
        gpio_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 pending value not applied", {gpio_out, gpio_oe}, 0);
        gpio_in = 8'h3C;
        act_single_trig = 1'b1;
        @(negedge clk);
        act_single_trig = 1'b0;
        chk("R11 value applied at trigger", gpio_out, 8'hA5);
        chk("R11 direction applied at trigger", gpio_oe, 8'h0F);
        chk("R11 input captured at trigger", gpio_in_lat, 8'h3C);
        gpio_in = 8'hFF;
        repeat (10) @(negedge clk);
        chk("R11 captured input held", gpio_in_lat, 8'h3C);
    endtask

    initial begin
        test_reset();
        run_train(9, 3, 1, 3, 3, 0);
        run_train(20, 1, 4, 3, 1, 0);
        run_train(9, 3, 1, 15, 2, 1);
        test_single();
        test_saturation();
        test_gpio();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule